// File: doc/BRIEF.md
# Dual-Rail Level-Encoded Bus Receiver

This block receives an N-bit word sent over a level-encoded, two-phase, dual-rail bus. Each bit travels on two wires. The value wire always shows the bit itself. The phase wire is set so that the XOR of the two wires gives the phase of the current item. Successive items alternate between even and odd phase. Each new item changes exactly one of the two wires of every bit. No separate strobe exists: the receiver decides that a word has arrived by watching each bit's phase.

Both rails pass through a register stage in the receiver clock domain. Per-bit logic then recovers each bit's phase, and word-wide detectors report when every bit is even or every bit is odd. When the whole word shows the expected phase, the value rails are captured and offered on a valid/ready output. The expected phase then flips. A word is never captured over an unconsumed one. The sender is expected to hold off its next item until the previous one has been taken.

Top module: `ledr_rx`

## Requirements
- R1: After reset, valid_o is low, and it stays low while the rails keep their reset level (all wires 0).
- R2: The phase of a bit is value XOR parity, where 0 is even and 1 is odd. After reset the rails count as even phase and the first word is expected in odd phase. The expected phase flips after each capture, so a word whose bits are all even right after reset is not taken.
- R3: A word is captured only when every bit shows the expected phase. While the bits arrive skewed and only some of them have changed phase, valid_o stays low.
- R4: The captured word_o equals the value rails of the completed word.
- R5: With SYNC_STAGES=2 and an empty output, valid_o rises on the third rising clock edge after the last rail change, and not before.
- R6: While valid_o is high and ready_i is low, valid_o stays high and word_o stays stable.
- R7: A completed word is not captured while the previous word is held. It is captured on the edge where the held word is accepted, so no word is lost.
- R8: Rails that stay in the already-captured phase produce no second capture, so no word is duplicated.
- R9: After an accepted transfer with no new completed word, valid_o goes low on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receiver clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| val_rail_i | input | WIDTH | Value wire of each bit |
| par_rail_i | input | WIDTH | Phase wire of each bit |
| word_o | output | WIDTH | Captured word |
| valid_o | output | 1 | Captured word is available |
| ready_i | input | 1 | Consumer accepts word_o this cycle |

## Verification
The assertions assume that the sender follows the protocol. Each bit moves by one wire per item, and no new item starts before the previous one has been captured. Otherwise a skewed or overrun word could mix phases in a way that no check can tell apart from a legal one. The bench encodes every item from the word value and the next phase, so only one wire per bit changes. It holds off each send until the scoreboard shows that the previous item has left or is sitting in the output register, and then waits a few more cycles for the input stage to settle. The one deliberate break of the protocol is the even-phase pattern driven right after reset. It is used only to show that the first expected phase is odd.

// File: rtl/ledr_rx_pkg.sv
package ledr_rx_pkg;
  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } phase_e;

  function automatic phase_e flip(phase_e p);
    return (p == PH_ODD) ? PH_EVEN : PH_ODD;
  endfunction
endpackage

// File: rtl/ledr_rx_sync.sv
module ledr_rx_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ledr_rx_bit_phase.sv
module ledr_rx_bit_phase
  import ledr_rx_pkg::*;
(
  input  logic val_i,
  input  logic par_i,
  output logic odd_o
);
  phase_e ph;

  assign ph    = phase_e'(val_i ^ par_i);
  assign odd_o = (ph == PH_ODD);
endmodule

// File: rtl/ledr_rx_detect.sv
module ledr_rx_detect #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] odd_i,
  output logic             all_even_o,
  output logic             all_odd_o
);
  assign all_even_o = ~|odd_i;
  assign all_odd_o  = &odd_i;
endmodule

// File: rtl/ledr_rx.sv
module ledr_rx
  import ledr_rx_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] val_rail_i,
  input  logic [WIDTH-1:0] par_rail_i,
  output logic [WIDTH-1:0] word_o,
  output logic             valid_o,
  input  logic             ready_i
);
  localparam int RailW = 2 * WIDTH;

  logic [RailW-1:0] rail_s;
  logic [WIDTH-1:0] val_s, par_s, odd_vec;
  logic             all_even, all_odd, complete, cap, expect_odd;
  phase_e           expect_q;
  logic [WIDTH-1:0] word_q;
  logic             valid_q;

  ledr_rx_sync #(.WIDTH(RailW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({par_rail_i, val_rail_i}),
    .q_o   (rail_s)
  );

  assign val_s = rail_s[WIDTH-1:0];
  assign par_s = rail_s[RailW-1:WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    ledr_rx_bit_phase u_ph (
      .val_i(val_s[i]),
      .par_i(par_s[i]),
      .odd_o(odd_vec[i])
    );
  end

  ledr_rx_detect #(.WIDTH(WIDTH)) u_det (
    .odd_i     (odd_vec),
    .all_even_o(all_even),
    .all_odd_o (all_odd)
  );

  assign expect_odd = (expect_q == PH_ODD);
  assign complete   = expect_odd ? all_odd : all_even;
  // free slot: empty, or the held word leaves on this edge
  assign cap        = complete && (!valid_q || ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      expect_q <= PH_ODD;
      word_q   <= '0;
      valid_q  <= 1'b0;
    end else if (cap) begin
      expect_q <= flip(expect_q);
      word_q   <= val_s;
      valid_q  <= 1'b1;
    end else if (ready_i) begin
      valid_q  <= 1'b0;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/ledr_rx_chk.sv
module ledr_rx_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_o,
  input logic             ready_i,
  input logic [WIDTH-1:0] word_o,
  input logic             cap,
  input logic             expect_odd,
  input logic             all_even,
  input logic             all_odd,
  input logic [WIDTH-1:0] val_s
);
  a_r2_phase_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |=> (expect_odd != $past(expect_odd)));

  a_r3_mixed_no_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!all_even && !all_odd) |=> $stable(expect_odd));

  a_r4_word_from_rails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |=> (valid_o && word_o == $past(val_s)));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(word_o)));

  a_r7_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> $stable(expect_odd));

  a_r9_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && !cap) |=> !valid_o);
endmodule

bind ledr_rx ledr_rx_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_o   (valid_o),
  .ready_i   (ready_i),
  .word_o    (word_o),
  .cap       (cap),
  .expect_odd(expect_odd),
  .all_even  (all_even),
  .all_odd   (all_odd),
  .val_s     (val_s)
);

// File: tb/ledr_rx_test.sv
module ledr_rx_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] val_r = '0, par_r = '0;
  logic [W-1:0] word_o;
  logic         valid_o;
  logic         ready_i = 1'b0;

  int n_chk = 0, n_err = 0, n_pop = 0, n_sent = 0;
  bit rnd_ready = 1'b0, done = 1'b0;
  bit nxt_odd = 1'b1;
  logic [W-1:0] exp_q[$];

  always #10 clk = ~clk;

  ledr_rx #(.WIDTH(W), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .val_rail_i(val_r), .par_rail_i(par_r),
    .word_o(word_o), .valid_o(valid_o), .ready_i(ready_i)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  // one wire per bit changes: value follows word, parity makes xor equal phase
  task automatic send(logic [W-1:0] w, bit skew);
    logic [W-1:0] p;
    p = w ^ {W{nxt_odd}};
    exp_q.push_back(w);
    n_sent++;
    if (!skew) begin
      val_r = w; par_r = p;
    end else begin
      for (int i = 0; i < W; i++) begin
        val_r[i] = w[i]; par_r[i] = p[i];
        if (i != W-1) begin
          tick(); tick(); tick();
          chk(valid_o == 1'b0, "R3 partial word", valid_o, 0);
        end
      end
    end
    nxt_odd = ~nxt_odd;
  endtask

  // scoreboard monitor, samples 2 ns before the rising edge
  always begin
    @(negedge clk); #8;
    if (rst_ni && valid_o && ready_i) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R8 duplicate word actual=%0h expected=none", word_o);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        if (word_o !== e) begin
          n_err++;
          $display("FAIL R4 word actual=%0h expected=%0h", word_o, e);
        end
      end
      n_pop++;
    end
  end

  always begin
    @(negedge clk); #1;
    if (rnd_ready) ready_i = 1'($urandom % 2);
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    repeat (6) tick();
    chk(valid_o == 1'b0, "R1 idle after reset", valid_o, 0);

    // R2: all bits even right after reset must not be taken
    val_r = 8'hFF; par_r = 8'hFF;
    repeat (6) tick();
    chk(valid_o == 1'b0, "R2 even phase ignored first", valid_o, 0);

    // R5 latency, ready held low
    send(8'hA5, 1'b0);
    tick(); tick();
    chk(valid_o == 1'b0, "R5 not before third edge", valid_o, 0);
    tick();
    chk(valid_o == 1'b1, "R5 valid on third edge", valid_o, 1);
    chk(word_o == 8'hA5, "R4 captured value", word_o, 8'hA5);

    repeat (5) tick();
    chk(valid_o == 1'b1 && word_o == 8'hA5, "R6 held under backpressure", word_o, 8'hA5);

    // R7: completed word waits behind held one
    send(8'h3C, 1'b0);
    repeat (6) tick();
    chk(word_o == 8'hA5, "R7 held word not overwritten", word_o, 8'hA5);
    ready_i = 1'b1;
    tick();
    ready_i = 1'b0;
    chk(valid_o == 1'b1 && word_o == 8'h3C, "R7 waiting word taken on release", word_o, 8'h3C);
    chk(n_pop == 1, "R7 one transfer", n_pop, 1);

    ready_i = 1'b1;
    tick();
    chk(valid_o == 1'b0, "R9 valid drops after transfer", valid_o, 0);
    repeat (10) tick();
    chk(valid_o == 1'b0 && n_pop == 2, "R8 no duplicate from stable rails", n_pop, 2);

    // R3 skewed arrival
    send(8'h5A, 1'b1);
    repeat (5) tick();
    chk(n_pop == 3, "R3 skewed word delivered once", n_pop, 3);
    send(8'hC3, 1'b1);
    repeat (5) tick();
    chk(n_pop == 4, "R3 skewed word in even phase", n_pop, 4);

    // stream with random backpressure
    rnd_ready = 1'b1;
    for (int k = 0; k < 300; k++) begin
      while (n_pop < n_sent - 1) tick();
      repeat (4) tick();
      send(W'($urandom), 1'b0);
    end
    for (int t = 0; t < 200 && n_pop < n_sent; t++) tick();
    rnd_ready = 1'b0;
    ready_i = 1'b1;
    repeat (10) tick();
    chk(n_pop == n_sent, "R7 no word lost in stream", n_pop, n_sent);
    chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
    chk(valid_o == 1'b0, "R9 idle at end", valid_o, 0);
    finish_run();
  end
endmodule